// File: doc/BRIEF.md
# Two-Mode Power Management Controller

This block decides which clocks of a small microcontroller are allowed to run. Software writes a mode request with two bits, one for idle and one for power-down. In idle the CPU clock is gated off. Memory, timers, serial ports and interrupt logic keep their clock. In power-down the oscillator enable is dropped, so every clocked function halts and memory holds its contents.

The controller itself runs from an always-on clock. It watches the wake sources and brings the device back to normal operation:
- Idle ends on any enabled interrupt request.
- Power-down ends only on a reset, a seconds-timer interrupt, or either of two external interrupt lines.
- After power-down, the CPU and peripheral clocks stay gated until the oscillator reports that it is stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces the run state. mode reads 2'b00, and cpu_clk_en, periph_clk_en and osc_en are all 1. This holds from any state, including power-down.
- R2: In run, a write (wr_en high) with wr_idle=1 and wr_pdown=0 enters idle on the next clock edge. mode reads 2'b01, cpu_clk_en is 0, and periph_clk_en and osc_en are 1. Interrupt requests present in that cycle do not cancel the entry.
- R3: In run, a write with wr_pdown=1 enters power-down on the next edge. mode reads 2'b10, and cpu_clk_en, periph_clk_en and osc_en are all 0.
- R4: A write with both wr_idle and wr_pdown set enters power-down, not idle.
- R5: In idle, any bit of irq_req being high returns the block to run (mode 2'b00) on the next edge.
- R6: In power-down, irq_req and osc_stable are ignored and the mode stays 2'b10. Only wake_ext0, wake_ext1 or wake_sec move the block to the restart state: mode 2'b11, osc_en 1, cpu_clk_en 0, periph_clk_en 0.
- R7: In the restart state the block waits for osc_stable. It moves to run on the first edge where osc_stable is sampled high. A stable indication present in the same cycle as the wake event does not skip the restart state.
- R8: Writes are ignored in idle. A write in run with neither bit set leaves the block in run.
- R9: In idle, the power-down wake lines have no effect unless an irq_req bit is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode request write strobe |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pdown | input | 1 | Power-down request bit of the write |
| irq_req | input | NIRQ | Enabled interrupt requests |
| wake_ext0 | input | 1 | External interrupt line 0 |
| wake_ext1 | input | 1 | External interrupt line 1 |
| wake_sec | input | 1 | Seconds-timer interrupt |
| osc_stable | input | 1 | Oscillator settled indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Memory, timer, serial and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 00 run, 01 idle, 10 power-down, 11 oscillator restart |

## Verification
Three pairs of events are driven in the same cycle:
- An idle request and an interrupt request while running. The bench expects idle, because an interrupt only ends an existing idle.
- A power-down wake line and osc_stable. The bench expects one cycle in the restart state before run.
- Both mode bits in one write. The bench expects power-down.

Each case is judged from mode and the three enables one cycle after the edge.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_idle,
  input  logic            wr_pdown,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            wake_ext0,
  input  logic            wake_ext1,
  input  logic            wake_sec,
  input  logic            osc_stable,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            osc_en,
  output logic [1:0]      mode
);
  localparam logic [1:0] M_RUN  = 2'b00;
  localparam logic [1:0] M_IDLE = 2'b01;
  localparam logic [1:0] M_PDN  = 2'b10;
  localparam logic [1:0] M_WARM = 2'b11;

  logic [1:0] st, nxt;
  logic       pd_wake, any_irq;

  assign pd_wake = wake_ext0 | wake_ext1 | wake_sec;
  assign any_irq = |irq_req;

  always_comb begin
    nxt = st;
    case (st)
      M_RUN:  if (wr_en && wr_pdown)     nxt = M_PDN;
              else if (wr_en && wr_idle) nxt = M_IDLE;
      M_IDLE: if (any_irq)               nxt = M_RUN;
      M_PDN:  if (pd_wake)               nxt = M_WARM;
      M_WARM: if (osc_stable)            nxt = M_RUN;
      default:                           nxt = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= M_RUN;
    else        st <= nxt;

  assign cpu_clk_en    = (st == M_RUN);
  assign periph_clk_en = (st == M_RUN) || (st == M_IDLE);
  assign osc_en        = (st != M_PDN);
  assign mode          = st;
endmodule

module pwr_mode_ctrl_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_idle,
  input logic            wr_pdown,
  input logic [NIRQ-1:0] irq_req,
  input logic            wake_ext0,
  input logic            wake_ext1,
  input logic            wake_sec,
  input logic            osc_stable,
  input logic            cpu_clk_en,
  input logic            periph_clk_en,
  input logic            osc_en,
  input logic [1:0]      mode
);
  assert_reset_run_R1: assert property (@(posedge clk)
    !rst_n |-> ##0 (mode == 2'b00 && cpu_clk_en && periph_clk_en && osc_en));

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_en && wr_idle && !wr_pdown)
    |=> (mode == 2'b01 && !cpu_clk_en && periph_clk_en));

  assert_pdown_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_en && wr_pdown && !wr_idle)
    |=> (!osc_en && !cpu_clk_en && !periph_clk_en));

  assert_pdown_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_en && wr_pdown && wr_idle) |=> (mode == 2'b10));

  assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && |irq_req) |=> (mode == 2'b00));

  assert_pdown_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !wake_ext0 && !wake_ext1 && !wake_sec) |=> (mode == 2'b10));

  assert_restart_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !osc_stable) |=> (mode == 2'b11 && !cpu_clk_en));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && irq_req == '0) |=> (mode == 2'b01));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idle(wr_idle),
  .wr_pdown(wr_pdown), .irq_req(irq_req), .wake_ext0(wake_ext0),
  .wake_ext1(wake_ext1), .wake_sec(wake_sec), .osc_stable(osc_stable),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .osc_en(osc_en), .mode(mode)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NIRQ = 8;

  logic clk = 1'b0;
  logic rst_n, wr_en, wr_idle, wr_pdown, wake_ext0, wake_ext1, wake_sec, osc_stable;
  logic [NIRQ-1:0] irq_req;
  logic cpu_clk_en, periph_clk_en, osc_en;
  logic [1:0] mode;

  typedef struct {
    logic [1:0] m;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idle(wr_idle),
    .wr_pdown(wr_pdown), .irq_req(irq_req), .wake_ext0(wake_ext0),
    .wake_ext1(wake_ext1), .wake_sec(wake_sec), .osc_stable(osc_stable),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .mode(mode)
  );

  task automatic step(input logic r, input logic we, input logic wi, input logic wp,
                      input logic [NIRQ-1:0] irq, input logic e0, input logic e1,
                      input logic s, input logic st, input logic [1:0] m,
                      input string req);
    exp_t e;
    @(negedge clk); #1;
    rst_n = r; wr_en = we; wr_idle = wi; wr_pdown = wp; irq_req = irq;
    wake_ext0 = e0; wake_ext1 = e1; wake_sec = s; osc_stable = st;
    @(posedge clk); #1;
    e.m = m; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic ec, ep, eo;
      e = q.pop_front();
      ec = (e.m == 2'b00);
      ep = (e.m == 2'b00) || (e.m == 2'b01);
      eo = (e.m != 2'b10);
      checks++;
      if (mode !== e.m || cpu_clk_en !== ec || periph_clk_en !== ep || osc_en !== eo) begin
        errors++;
        $display("FAIL %s: mode/cpu/periph/osc actual %b/%b/%b/%b expected %b/%b/%b/%b",
                 e.req, mode, cpu_clk_en, periph_clk_en, osc_en, e.m, ec, ep, eo);
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_idle = 0; wr_pdown = 0; irq_req = '0;
    wake_ext0 = 0; wake_ext1 = 0; wake_sec = 0; osc_stable = 0;
    step(0,0,0,0,'0,0,0,0,0, 2'b00, "R1");
    step(1,0,0,0,'0,0,0,0,0, 2'b00, "R1");
    step(1,1,0,0,'0,0,0,0,0, 2'b00, "R8");
    step(1,1,1,0,'0,0,0,0,0, 2'b01, "R2");
    step(1,1,0,1,'0,0,0,0,0, 2'b01, "R8");
    step(1,0,0,0,'0,1,1,1,0, 2'b01, "R9");
    step(1,0,0,0,8'h80,0,0,0,0, 2'b00, "R5");
    step(1,1,1,1,'0,0,0,0,0, 2'b10, "R4");
    step(1,0,0,0,8'hFF,0,0,0,1, 2'b10, "R6");
    step(1,1,1,0,'0,0,0,0,0, 2'b10, "R6");
    step(1,0,0,0,'0,0,0,1,0, 2'b11, "R6");
    step(1,0,0,0,'0,0,0,0,0, 2'b11, "R7");
    step(1,0,0,0,'0,0,0,0,1, 2'b00, "R7");
    step(1,1,0,1,'0,0,0,0,0, 2'b10, "R3");
    step(1,0,0,0,'0,0,1,0,1, 2'b11, "R7");
    step(1,0,0,0,'0,0,0,0,1, 2'b00, "R7");
    step(1,1,1,0,8'h01,0,0,0,0, 2'b01, "R2");
    step(1,0,0,0,8'h01,0,0,0,0, 2'b00, "R5");
    step(1,1,0,1,'0,0,0,0,0, 2'b10, "R3");
    step(1,0,0,0,'0,1,0,0,0, 2'b11, "R6");
    step(1,0,0,0,'0,0,0,0,1, 2'b00, "R7");
    step(1,1,0,1,'0,0,0,0,0, 2'b10, "R3");
    step(0,0,0,0,'0,0,0,0,0, 2'b00, "R1");
    step(1,0,0,0,'0,0,0,0,0, 2'b00, "R1");
    wait (q.size() == 0);
    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule